// File: doc/BRIEF.md
# Stream port transfer controller

This block sits between the memory stage of a 32-bit soft processor and a point-to-point stream link. The core hands it one decoded transfer request at a time. The request carries a 3-bit variant code, a channel number and a write word. The controller raises a strobe on the link and holds the request fields steady while it waits for the link's acknowledge. It stalls the core while the transfer is open. It then reports completion, whether the transfer succeeded, and, for a read, the received word for the load writeback path.

The variant code splits into three independent bits. Bit 2 selects the direction: 1 writes to the link, 0 reads from it. Bit 1 selects the waiting policy: 0 waits for the acknowledge with no time limit, 1 gives up after `NB_WAIT` strobe cycles. Bit 0 marks the word as a control word rather than data. The controller keeps one sequencer with three states:
- `ST_IDLE` waits for a request.
- `ST_HOLD` is a blocking transfer waiting for the acknowledge.
- `ST_POLL` is a non-blocking transfer watched by a cycle counter.

The transitions are:
- *accept-blocking*: `ST_IDLE` to `ST_HOLD`.
- *accept-polling*: `ST_IDLE` to `ST_POLL`.
- *hold-acked*: `ST_HOLD` to `ST_IDLE`.
- *poll-acked*: `ST_POLL` to `ST_IDLE`.
- *poll-expired*: `ST_POLL` to `ST_IDLE`, when the window runs out.

Top module: `stream_xfer_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in `ST_IDLE` from the next cycle. In that state `lnk_stb_o`, `core_stall_o`, `core_done_o`, `core_load_o` and `core_fail_o` are 0 and `core_rdata_o` is 0. Reset also cancels an open transfer.
- R2: If `req_valid_i` is high at an edge while the block is idle, then from the next cycle `lnk_stb_o` and `core_stall_o` are 1. In that cycle `lnk_chan_o` and `lnk_wdata_o` carry the request's channel and word. `lnk_chan_o` is the link's word address bits 6 down to 2.
- R3: The variant code decodes bitwise. Bit 2 drives `lnk_we_o` (1 = put, 0 = get). Bit 1 set means non-blocking. Bit 0 drives `lnk_ctl_o` (control word). So code 0 is a blocking data get, 4 a blocking data put, 2 a non-blocking data get, 6 a non-blocking data put, 1 a blocking control get, 5 a blocking control put, 3 a non-blocking control get and 7 a non-blocking control put.
- R4: In a blocking transfer, `lnk_stb_o` and `core_stall_o` stay 1 for as many cycles as the acknowledge takes.
- R5: `lnk_stb_o` and `core_stall_o` are 0 in the cycle after an edge where `lnk_ack_i` was high with the strobe open. `core_done_o` is 1 for exactly that one cycle.
- R6: In a non-blocking transfer with no acknowledge, the strobe is open for exactly `NB_WAIT` cycles. Then strobe and stall drop, `core_done_o` pulses and `core_fail_o` becomes 1.
- R7: A non-blocking transfer acknowledged within its window, including in its last cycle, completes with `core_fail_o` = 0.
- R8: A successful get loads `core_rdata_o` with the `lnk_rdata_i` value present at the acknowledging edge. A put or a failed get leaves `core_rdata_o` unchanged.
- R9: `req_valid_i` is ignored while a transfer is open. Link-side fields stay at the accepted values until the strobe drops.
- R10: `core_load_o` pulses together with `core_done_o` only for a successful get.
- R11: `core_fail_o` keeps the outcome of the last completed transfer until the next one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Transfer request from the core |
| req_kind_i | input | 3 | Variant code (direction, waiting policy, control tag) |
| req_chan_i | input | CHAN_W | Channel number |
| req_wdata_i | input | DATA_W | Word to send on a put |
| core_rdata_o | output | DATA_W | Last word received by a successful get |
| core_stall_o | output | 1 | Transfer open, core must hold |
| core_done_o | output | 1 | One-cycle completion pulse |
| core_load_o | output | 1 | One-cycle pulse: received word ready for writeback |
| core_fail_o | output | 1 | Last transfer timed out (carry-style status) |
| lnk_stb_o | output | 1 | Link strobe |
| lnk_we_o | output | 1 | Link write enable |
| lnk_ctl_o | output | 1 | Control-word tag |
| lnk_chan_o | output | CHAN_W | Channel address (link address bits 6..2) |
| lnk_wdata_o | output | DATA_W | Word toward the link |
| lnk_rdata_i | input | DATA_W | Word from the link |
| lnk_ack_i | input | 1 | Link acknowledge |

## Verification
A sequencer stuck in the wrong state shows up within one cycle of the edge concerned. The strobe fails to rise after acceptance, or stays high after an acknowledge, and the stall output follows it. A window counter that is off by one moves the completion pulse and the fail flag by one cycle. Directed cases therefore acknowledge in the last allowed cycle and one cycle too late. A wrongly latched request or read word appears on the link fields or `core_rdata_o` in the first strobe cycle, or in the completion cycle. Requests injected mid-transfer show any field that is not held.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_POLL = 2'd2
    } sxc_state_e;

    // bit positions inside the variant code
    localparam int KIND_W     = 3;
    localparam int KIND_DIR   = 2;
    localparam int KIND_NOBLK = 1;
    localparam int KIND_CTL   = 0;

    typedef struct packed {
        logic put;
        logic nonblk;
        logic ctl;
    } sxc_kind_t;

endpackage

// File: rtl/sxc_kind_dec.sv
module sxc_kind_dec
    import sxc_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    output sxc_kind_t         kind_o
);

    always_comb begin
        kind_o.put    = kind_i[KIND_DIR];
        kind_o.nonblk = kind_i[KIND_NOBLK];
        kind_o.ctl    = kind_i[KIND_CTL];
    end

endmodule

// File: rtl/sxc_timer.sv
module sxc_timer #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expire_o
);

    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/sxc_fsm.sv
module sxc_fsm
    import sxc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic nonblk_i,
    input  logic ack_i,
    input  logic expire_i,
    output logic busy_o,
    output logic poll_o,
    output logic accept_o,
    output logic finish_o,
    output logic timeout_o
);

    sxc_state_e state_q;
    sxc_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i)              state_d = nonblk_i ? ST_POLL : ST_HOLD;
            ST_HOLD: if (ack_i)              state_d = ST_IDLE;
            ST_POLL: if (ack_i || expire_i)  state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o    = 1'b0;
        poll_o    = 1'b0;
        accept_o  = 1'b0;
        finish_o  = 1'b0;
        timeout_o = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = req_i;
            ST_HOLD: begin
                busy_o   = 1'b1;
                finish_o = ack_i;
            end
            ST_POLL: begin
                busy_o    = 1'b1;
                poll_o    = 1'b1;
                finish_o  = ack_i || expire_i;
                timeout_o = !ack_i && expire_i;
            end
            default: ;
        endcase
    end

    // R4
    hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !ack_i) |=> (state_q == ST_HOLD));

    // R5
    finish_idle_chk: assert property (@(posedge clk) disable iff (rst)
        finish_o |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sxc_xfer_regs.sv
module sxc_xfer_regs #(
    parameter int CHAN_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              finish_i,
    input  logic              timeout_i,
    input  logic              put_i,
    input  logic              ctl_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] lnk_rdata_i,
    output logic              we_o,
    output logic              ctl_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              load_o,
    output logic              fail_o
);

    logic got_word;
    assign got_word = finish_i && !timeout_i && !we_o;

    // request fields, captured once per transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            we_o    <= 1'b0;
            ctl_o   <= 1'b0;
            chan_o  <= '0;
            wdata_o <= '0;
        end else if (accept_i) begin
            we_o    <= put_i;
            ctl_o   <= ctl_i;
            chan_o  <= chan_i;
            wdata_o <= wdata_i;
        end
    end

    // completion results toward the core
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            done_o  <= 1'b0;
            load_o  <= 1'b0;
            fail_o  <= 1'b0;
        end else begin
            done_o <= finish_i;
            load_o <= got_word;
            if (got_word) begin
                rdata_o <= lnk_rdata_i;
            end
            if (finish_i) begin
                fail_o <= timeout_i;
            end
        end
    end

    // R10
    load_ok_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |-> (done_o && !fail_o && !we_o));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/stream_xfer_ctl.sv
module stream_xfer_ctl
    import sxc_pkg::*;
#(
    parameter int CHAN_W  = 5,
    parameter int DATA_W  = 32,
    parameter int NB_WAIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [2:0]        req_kind_i,
    input  logic [CHAN_W-1:0] req_chan_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic [DATA_W-1:0] core_rdata_o,
    output logic              core_stall_o,
    output logic              core_done_o,
    output logic              core_load_o,
    output logic              core_fail_o,
    output logic              lnk_stb_o,
    output logic              lnk_we_o,
    output logic              lnk_ctl_o,
    output logic [CHAN_W-1:0] lnk_chan_o,
    output logic [DATA_W-1:0] lnk_wdata_o,
    input  logic [DATA_W-1:0] lnk_rdata_i,
    input  logic              lnk_ack_i
);

    sxc_kind_t kind;
    logic      busy, poll, accept, finish, timeout, expire;

    sxc_kind_dec u_dec (
        .kind_i (req_kind_i),
        .kind_o (kind)
    );

    sxc_timer #(.LIMIT(NB_WAIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (poll),
        .expire_o (expire)
    );

    sxc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_valid_i),
        .nonblk_i  (kind.nonblk),
        .ack_i     (lnk_ack_i),
        .expire_i  (expire),
        .busy_o    (busy),
        .poll_o    (poll),
        .accept_o  (accept),
        .finish_o  (finish),
        .timeout_o (timeout)
    );

    sxc_xfer_regs #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .finish_i    (finish),
        .timeout_i   (timeout),
        .put_i       (kind.put),
        .ctl_i       (kind.ctl),
        .chan_i      (req_chan_i),
        .wdata_i     (req_wdata_i),
        .lnk_rdata_i (lnk_rdata_i),
        .we_o        (lnk_we_o),
        .ctl_o       (lnk_ctl_o),
        .chan_o      (lnk_chan_o),
        .wdata_o     (lnk_wdata_o),
        .rdata_o     (core_rdata_o),
        .done_o      (core_done_o),
        .load_o      (core_load_o),
        .fail_o      (core_fail_o)
    );

    assign lnk_stb_o    = busy;
    assign core_stall_o = busy;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!lnk_stb_o && !core_done_o && !core_fail_o));

    // R5
    stb_release_chk: assert property (@(posedge clk) disable iff (rst)
        (lnk_stb_o && lnk_ack_i) |=> !lnk_stb_o);

    // R2
    accept_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!lnk_stb_o && req_valid_i) |=> lnk_stb_o);

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lnk_stb_o && !finish) |=> ($stable(lnk_chan_o) && $stable(lnk_wdata_o)
                                    && $stable(lnk_we_o) && $stable(lnk_ctl_o)));

    // R11
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(core_fail_o));

endmodule

// File: tb/stream_xfer_ctl_tb_top.sv
`timescale 1ns/1ps
module stream_xfer_ctl_tb_top;

    localparam int NBW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [2:0]  req_kind_i = '0;
    logic [4:0]  req_chan_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic [31:0] lnk_rdata_i = '0;
    logic        lnk_ack_i = 1'b0;
    logic [31:0] core_rdata_o;
    logic        core_stall_o, core_done_o, core_load_o, core_fail_o;
    logic        lnk_stb_o, lnk_we_o, lnk_ctl_o;
    logic [4:0]  lnk_chan_o;
    logic [31:0] lnk_wdata_o;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    logic [31:0] exp_rdata = '0;
    logic        exp_fail  = 1'b0;

    always #2.5 clk = ~clk;

    stream_xfer_ctl #(.CHAN_W(5), .DATA_W(32), .NB_WAIT(NBW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
        .req_chan_i(req_chan_i), .req_wdata_i(req_wdata_i),
        .core_rdata_o(core_rdata_o), .core_stall_o(core_stall_o),
        .core_done_o(core_done_o), .core_load_o(core_load_o),
        .core_fail_o(core_fail_o),
        .lnk_stb_o(lnk_stb_o), .lnk_we_o(lnk_we_o), .lnk_ctl_o(lnk_ctl_o),
        .lnk_chan_o(lnk_chan_o), .lnk_wdata_o(lnk_wdata_o),
        .lnk_rdata_i(lnk_rdata_i), .lnk_ack_i(lnk_ack_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit fn_fails(input logic [2:0] kind, input int lat);
        return kind[1] && (lat >= NBW);
    endfunction

    function automatic int fn_last_cycle(input logic [2:0] kind, input int lat);
        return fn_fails(kind, lat) ? NBW - 1 : lat;
    endfunction

    // one transfer; lat = strobe cycle index in which the link acknowledges
    task automatic run_xfer(input logic [2:0] kind, input logic [4:0] ch,
                            input logic [31:0] wd, input int lat, input bit noise);
        int last;
        bit acked;
        last = fn_last_cycle(kind, lat);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_kind_i  = kind;
        req_chan_i  = ch;
        req_wdata_i = wd;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R11 fail held into next transfer", 32'(core_fail_o), 32'(exp_fail));
        for (int k = 0; k <= last; k++) begin
            chk("R2/R4 strobe open", 32'(lnk_stb_o), 32'd1);
            chk("R4 stall open", 32'(core_stall_o), 32'd1);
            chk("R3 write enable from bit 2", 32'(lnk_we_o), 32'(kind[2]));
            chk("R3 control tag from bit 0", 32'(lnk_ctl_o), 32'(kind[0]));
            chk("R2/R9 channel", 32'(lnk_chan_o), 32'(ch));
            chk("R2/R9 write word", lnk_wdata_o, wd);
            acked = (k == lat);
            lnk_ack_i   = acked;
            lnk_rdata_i = $urandom;
            if (acked && !kind[2]) exp_rdata = lnk_rdata_i;
            if (noise && k != last) begin
                req_valid_i = 1'b1;
                req_kind_i  = 3'($urandom);
                req_chan_i  = 5'($urandom);
                req_wdata_i = $urandom;
            end
            @(negedge clk);
            lnk_ack_i   = 1'b0;
            req_valid_i = 1'b0;
            if (k == last) begin
                exp_fail = fn_fails(kind, lat);
                chk("R5/R6 strobe released", 32'(lnk_stb_o), 32'd0);
                chk("R5/R6 stall released", 32'(core_stall_o), 32'd0);
                chk("R5 done pulse", 32'(core_done_o), 32'd1);
                chk("R6/R7 fail flag", 32'(core_fail_o), 32'(exp_fail));
                chk("R10 load pulse", 32'(core_load_o), 32'(!kind[2] && !exp_fail));
                chk("R8 read word", core_rdata_o, exp_rdata);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'h1F0A_5EED));
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", 32'(lnk_stb_o), 32'd0);
        chk("R1 stall in reset", 32'(core_stall_o), 32'd0);
        chk("R1 fail in reset", 32'(core_fail_o), 32'd0);
        chk("R1 rdata in reset", core_rdata_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", 32'(lnk_stb_o), 32'd0);

        // every variant code, immediate acknowledge (R3)
        for (int v = 0; v < 8; v++) begin
            run_xfer(3'(v), 5'(v + 3), 32'hA500_0000 | 32'(v), 0, 1'b0);
        end
        // long blocking waits (R4)
        run_xfer(3'd0, 5'd31, 32'h1234_5678, 15, 1'b1);
        run_xfer(3'd5, 5'd1, 32'hCAFE_F00D, 9, 1'b1);
        // non-blocking window edges (R6, R7)
        run_xfer(3'd2, 5'd7, 32'h0, NBW - 1, 1'b0);
        run_xfer(3'd3, 5'd8, 32'h1, NBW, 1'b0);
        run_xfer(3'd6, 5'd9, 32'h2, NBW + 4, 1'b1);
        run_xfer(3'd7, 5'd10, 32'h3, 0, 1'b0);
        // failed get keeps earlier word (R8), then done is a single pulse (R5)
        run_xfer(3'd2, 5'd11, 32'h4, NBW + 1, 1'b0);
        @(negedge clk);
        chk("R5 done lasts one cycle", 32'(core_done_o), 32'd0);
        chk("R10 load lasts one cycle", 32'(core_load_o), 32'd0);
        // acknowledge while idle changes nothing (R9)
        lnk_ack_i = 1'b1;
        @(negedge clk);
        lnk_ack_i = 1'b0;
        chk("R9 idle ack ignored", 32'(core_done_o), 32'd0);
        chk("R9 idle ack keeps word", core_rdata_o, exp_rdata);

        // constrained random mix
        for (int n = 0; n < 80; n++) begin
            logic [2:0] kind;
            int lat;
            kind = 3'($urandom);
            lat  = kind[1] ? int'($urandom % (NBW + 2)) : int'($urandom % 12);
            run_xfer(kind, 5'($urandom), $urandom, lat, 1'($urandom));
        end

        // reset cancels an open transfer (R1)
        @(negedge clk);
        req_valid_i = 1'b1;
        req_kind_i  = 3'd0;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R2 strobe before reset", 32'(lnk_stb_o), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset drops strobe", 32'(lnk_stb_o), 32'd0);
        chk("R1 reset drops stall", 32'(core_stall_o), 32'd0);
        chk("R1 reset clears fail", 32'(core_fail_o), 32'd0);
        chk("R1 reset clears word", core_rdata_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule